// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is an asynchronous serial transmitter and receiver sitting behind a byte-wide register interface with four addresses. Software reaches it through a 2-bit offset, a write strobe, a read strobe and an 8-bit data bus. The four registers are a reset/line-status register, a rate-select register, a control/status register and a data register. The transmitter and the receiver each run from their own tick generator. Each generator runs at 16 times the bit rate and is picked from a 16-entry rate table.

Characters carry 5 to 8 data bits, sent least significant bit first. An optional odd or even parity bit follows the data, then one or two stop bits. Two modem-control outputs are driven from the control register. Four modem-status inputs, together with the received line level, can be read back. A write of any value to offset 0 returns the whole block to its power-up state.

Top module: `sio_port`

## Requirements
- R1: A write of any data value to offset 0 clears data-available, overrun, framing and parity flags. It empties and stops the transmitter and returns the line to idle high. It restores the default configuration, so `dtr_n` and `rts_n` go high.
- R2: A read of offset 0 returns {cts, dsr, dcd_n, ri, 0, 0, line, 0}, bit 7 first. Here `line` is the synchronized `ser_in` level. A read of offset 1 returns 0.
- R3: A write to offset 1 sets the rates: bits 3:0 select the receive rate and bits 7:4 the transmit rate. Codes 0..15 select 50, 75, 100, 134.5, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200, 9600 and 19200 baud. One bit lasts 16 x round(CLK_HZ / (16 x rate)) clock cycles.
- R4: After reset both directions run at 300 baud (code 0x55) with 8 data bits, 1 stop bit and no parity. The transmitter is disabled and `dtr_n`/`rts_n` are high.
- R5: A write to offset 2 sets the control register. Bit 7 selects even parity when 1 and odd when 0. Bits 6:5 are the word length, bit 4 selects two stop bits when 1, and bit 3 disables parity when 1. Bit 2 enables the transmitter when 1. Bit 1 drives `dtr_n` and bit 0 drives `rts_n` directly, both active low.
- R6: Word length codes are 00 = 5, 01 = 7, 10 = 6 and 11 = 8 bits. Data is sent least significant bit first. A received character is right-justified in the data register, with unused upper bits reading 0.
- R7: When parity is enabled, one parity bit follows the last data bit. It makes the count of ones in data plus parity even (even mode) or odd (odd mode).
- R8: The transmitter sends one or two high stop bits after each character. Characters sent back to back start 10 or 11 bit periods apart for 8-bit frames without parity.
- R9: A read of offset 2 returns {data-available, transmit-holding-empty, overrun, framing error, parity error, 0, 0, 0}. Transmit-holding-empty is 0 from a data write until the byte moves into the shifter.
- R10: A read of offset 3 returns the last received character and clears data-available and overrun. A character that completes while data-available is set sets overrun and replaces the stored character.
- R11: The framing error flag is set when the first stop bit samples low. The parity error flag is set when the received parity bit mismatches. Both flags describe the most recently received character.
- R12: A byte written to offset 3 while the transmitter is disabled is held and the line stays high. Transmission of that byte starts once the enable bit is set.
- R13: The receiver confirms a start bit at mid-bit. A low pulse shorter than half a bit period is ignored and produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |
| cts | input | 1 | Clear-to-send status |
| dsr | input | 1 | Data-set-ready status |
| dcd_n | input | 1 | Carrier detect, active low |
| ri | input | 1 | Ring indicate status |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The bench builds the block with CLK_HZ = 3,072,000. With that clock every rate the bench uses divides to an integer tick: 10 cycles at 19200, 20 at 9600 and 640 at 300. Bit periods are then exact, and a 19200-baud frame takes under 2,000 cycles, so many loopback and directly driven frames fit in the run. The 300-baud reset default is checked once, by timing a single data bit before a register reset aborts the frame. Split rates are checked by timing the transmitter at 9600 while the bench drives the receiver at 19200.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef struct packed {
    logic [11:0] bits;
    logic [3:0]  len;
  } frame_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_t;

  // rate in tenths of a baud for each 4-bit selector code
  function automatic int unsigned rate_x10(input logic [3:0] code);
    case (code)
      4'd0:  return 500;
      4'd1:  return 750;
      4'd2:  return 1000;
      4'd3:  return 1345;
      4'd4:  return 1500;
      4'd5:  return 3000;
      4'd6:  return 6000;
      4'd7:  return 12000;
      4'd8:  return 18000;
      4'd9:  return 20000;
      4'd10: return 24000;
      4'd11: return 36000;
      4'd12: return 48000;
      4'd13: return 72000;
      4'd14: return 96000;
      default: return 192000;
    endcase
  endfunction

  // clock cycles per 16x tick, rounded to nearest, never below 2
  function automatic int unsigned tick_div(input longint unsigned clk_hz, input logic [3:0] code);
    longint unsigned den;
    longint unsigned q;
    den = 64'(rate_x10(code)) * 64'd16;
    q = (clk_hz * 64'd10 + den / 64'd2) / den;
    if (q < 64'd2) q = 64'd2;
    return 32'(q);
  endfunction

  // word length field: 00=5, 01=7, 10=6, 11=8
  function automatic logic [3:0] data_len(input logic [1:0] wl);
    case (wl)
      2'b00: return 4'd5;
      2'b01: return 4'd7;
      2'b10: return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic odd_even_bit(input logic [7:0] d, input logic even);
    return even ? (^d) : ~(^d);
  endfunction

  // line bits LSB first: start, data, optional parity, stop bits
  function automatic frame_t build_frame(input logic [7:0] d, input logic [1:0] wl,
                                         input logic par_en, input logic even,
                                         input logic two_stop);
    frame_t f;
    logic [3:0] n;
    logic [7:0] m;
    int pos;
    n = data_len(wl);
    m = d & (8'hFF >> (4'd8 - n));
    f.bits = '1;
    f.bits[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(n)) f.bits[i+1] = m[i];
    pos = int'(n) + 1;
    if (par_en) begin
      f.bits[pos] = odd_even_bit(m, even);
      pos++;
    end
    pos = pos + (two_stop ? 2 : 1);
    f.len = 4'(pos);
    return f;
  endfunction

endpackage

// File: rtl/sio_tick.sv
module sio_tick #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [3:0] code,
  output logic       tick
);
  localparam int unsigned MAX_DIV = sio_pkg::tick_div(64'(CLK_HZ), 4'd0);
  localparam int DW = $clog2(MAX_DIV + 1);

  logic [DW-1:0] lim_tab [16];
  logic [DW-1:0] cnt;
  logic [DW-1:0] lim;

  for (genvar g = 0; g < 16; g++) begin : g_tab
    assign lim_tab[g] = DW'(sio_pkg::tick_div(64'(CLK_HZ), 4'(g)) - 1);
  end

  assign lim = lim_tab[code];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R3: the divisor is at least 2, so a tick never lasts two cycles
  a_r3_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/sio_tx.sv
module sio_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       tx_en,
  input  logic [1:0] wl,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       hold_empty,
  output logic       ser_out
);
  import sio_pkg::*;

  logic [7:0]  hold_q;
  logic        hold_full;
  logic        busy;
  logic [11:0] shreg;
  logic [3:0]  len_q;
  logic [3:0]  tcnt;
  logic [3:0]  bcnt;
  frame_t      next_fr;
  logic        load_go;

  assign next_fr = build_frame(hold_q, wl, par_en, par_even, two_stop);
  assign load_go = !busy && hold_full && tx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      shreg     <= '1;
      len_q     <= '0;
      tcnt      <= '0;
      bcnt      <= '0;
    end else if (clr) begin
      hold_full <= 1'b0;
      busy      <= 1'b0;
      shreg     <= '1;
      tcnt      <= '0;
      bcnt      <= '0;
    end else begin
      if (wr) begin
        hold_q    <= wdata;
        hold_full <= 1'b1;
      end
      if (load_go) begin
        shreg <= next_fr.bits;
        len_q <= next_fr.len;
        busy  <= 1'b1;
        tcnt  <= '0;
        bcnt  <= '0;
        if (!wr) hold_full <= 1'b0;
      end else if (busy && tick) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == 4'd15) begin
          shreg <= {1'b1, shreg[11:1]};
          bcnt  <= bcnt + 1'b1;
          if (bcnt == len_q - 4'd1) busy <= 1'b0;
        end
      end
    end
  end

  assign hold_empty = !hold_full;
  assign ser_out    = busy ? shreg[0] : 1'b1;

  // R12: a disabled transmitter never starts a character
  a_r12_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_en) |=> !busy);

  // R9: a data write always leaves the holding register full next cycle
  a_r9_hold_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> !hold_empty);

endmodule

// File: rtl/sio_rx.sv
module sio_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] wl,
  input  logic       par_en,
  input  logic       par_even,
  output logic       done,
  output logic [7:0] data,
  output logic       frame_err,
  output logic       par_err
);
  import sio_pkg::*;

  rx_state_t  st;
  logic       line_q;
  logic [3:0] tcnt;
  logic [3:0] bcnt;
  logic [7:0] sh;
  logic       par_q;
  logic [3:0] nb;
  logic [7:0] just;
  logic       exp_par;

  assign nb      = data_len(wl);
  assign just    = sh >> (4'd8 - nb);
  assign exp_par = odd_even_bit(just, par_even);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      line_q    <= 1'b1;
      tcnt      <= '0;
      bcnt      <= '0;
      sh        <= '0;
      par_q     <= 1'b0;
      done      <= 1'b0;
      data      <= '0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      line_q <= line;
      done   <= 1'b0;
      if (clr) begin
        st   <= RX_IDLE;
        tcnt <= '0;
        bcnt <= '0;
      end else begin
        unique case (st)
          RX_IDLE: begin
            if (line_q && !line) begin
              st   <= RX_START;
              tcnt <= '0;
            end
          end
          RX_START: if (tick) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == 4'd7) begin
              tcnt <= '0;
              bcnt <= '0;
              st   <= line ? RX_IDLE : RX_DATA;
            end
          end
          RX_DATA: if (tick) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == 4'd15) begin
              sh   <= {line, sh[7:1]};
              bcnt <= bcnt + 1'b1;
              if (bcnt == nb - 4'd1) st <= par_en ? RX_PAR : RX_STOP;
            end
          end
          RX_PAR: if (tick) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == 4'd15) begin
              par_q <= line;
              st    <= RX_STOP;
            end
          end
          default: if (tick) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == 4'd15) begin
              done      <= 1'b1;
              data      <= just;
              frame_err <= !line;
              par_err   <= par_en && (par_q != exp_par);
              st        <= RX_IDLE;
            end
          end
        endcase
      end
    end
  end

  // R11: completion is a single-cycle event per character
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13: the receiver only leaves idle on a high-to-low transition
  a_r13_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_IDLE && !clr && !(line_q && !line)) |=> st == RX_IDLE);

endmodule

// File: rtl/sio_port.sv
module sio_port #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ser_in,
  output logic       ser_out,
  input  logic       cts,
  input  logic       dsr,
  input  logic       dcd_n,
  input  logic       ri,
  output logic       dtr_n,
  output logic       rts_n
);
  localparam logic [7:0] BAUD_DEF = 8'h55;
  localparam logic [7:0] CTRL_DEF = 8'h6B;

  logic [7:0] baud_q, ctrl_q, rbuf;
  logic       dav, oe, fe, pe;
  logic [1:0] sync_q;
  logic       line_s;
  logic       soft_clr, rd_data, tx_wr;
  logic       tick_rx, tick_tx;
  logic       rx_done, rx_fe, rx_pe;
  logic [7:0] rx_data;
  logic       hold_empty;

  assign soft_clr = reg_wr && (reg_addr == 2'd0);
  assign tx_wr    = reg_wr && (reg_addr == 2'd3);
  assign rd_data  = reg_rd && (reg_addr == 2'd3);
  assign line_s   = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], ser_in};
  end

  sio_tick #(.CLK_HZ(CLK_HZ)) u_tick_rx (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .code(baud_q[3:0]), .tick(tick_rx));

  sio_tick #(.CLK_HZ(CLK_HZ)) u_tick_tx (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .code(baud_q[7:4]), .tick(tick_tx));

  sio_tx u_tx (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .tick(tick_tx),
    .tx_en(ctrl_q[2]), .wl(ctrl_q[6:5]), .par_en(!ctrl_q[3]),
    .par_even(ctrl_q[7]), .two_stop(ctrl_q[4]),
    .wr(tx_wr), .wdata(reg_wdata), .hold_empty(hold_empty), .ser_out(ser_out));

  sio_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .tick(tick_rx), .line(line_s),
    .wl(ctrl_q[6:5]), .par_en(!ctrl_q[3]), .par_even(ctrl_q[7]),
    .done(rx_done), .data(rx_data), .frame_err(rx_fe), .par_err(rx_pe));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q <= BAUD_DEF;
      ctrl_q <= CTRL_DEF;
      rbuf   <= '0;
      dav    <= 1'b0;
      oe     <= 1'b0;
      fe     <= 1'b0;
      pe     <= 1'b0;
    end else if (soft_clr) begin
      baud_q <= BAUD_DEF;
      ctrl_q <= CTRL_DEF;
      dav    <= 1'b0;
      oe     <= 1'b0;
      fe     <= 1'b0;
      pe     <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 2'd1) baud_q <= reg_wdata;
      if (reg_wr && reg_addr == 2'd2) ctrl_q <= reg_wdata;
      if (rd_data) begin
        dav <= 1'b0;
        oe  <= 1'b0;
      end
      if (rx_done) begin
        rbuf <= rx_data;
        fe   <= rx_fe;
        pe   <= rx_pe;
        dav  <= 1'b1;
        if (dav && !rd_data) oe <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      2'd0: reg_rdata = {cts, dsr, dcd_n, ri, 2'b00, line_s, 1'b0};
      2'd1: reg_rdata = 8'h00;
      2'd2: reg_rdata = {dav, hold_empty, oe, fe, pe, 3'b000};
      default: reg_rdata = rbuf;
    endcase
  end

  assign dtr_n = ctrl_q[1];
  assign rts_n = ctrl_q[0];

  // R1: a write to offset 0 leaves flags clear, outputs inactive, line idle
  a_r1_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!dav && !oe && !fe && !pe && dtr_n && rts_n && ser_out));

  // R10: a character arriving on unread data raises overrun
  a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && dav && !rd_data && !soft_clr) |=> oe);

  // R10: reading data drops data-available unless a new one lands
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_done) |=> !dav);

endmodule

// File: tb/sim_sio_port.sv
`timescale 1ns/1ps
module sim_sio_port;
  localparam int unsigned CLK_HZ = 3_072_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ser_out, dtr_n, rts_n;
  logic       cts = 1'b0, dsr = 1'b0, dcd_n = 1'b1, ri = 1'b0;
  logic       loop = 1'b0;
  logic       drv_line = 1'b1;
  logic       ser_in;
  int         n_chk = 0;
  int         n_err = 0;
  bit         finished = 1'b0;

  assign ser_in = loop ? ser_out : drv_line;

  always #10 clk = ~clk;

  sio_port #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_in(ser_in), .ser_out(ser_out),
    .cts(cts), .dsr(dsr), .dcd_n(dcd_n), .ri(ri), .dtr_n(dtr_n), .rts_n(rts_n));

  function automatic int bit_cycles(input real rate);
    return 16 * $rtoi(real'(CLK_HZ) / (16.0 * rate) + 0.5);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input string what, input int act, input int exp, input int tol);
    n_chk++;
    if (act > exp + tol || act < exp - tol) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input string what, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic setup(input logic [7:0] baud, input logic [7:0] ctrl, input logic lp);
    loop = lp;
    drv_line = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h00);
    wr(2'd1, baud);
    wr(2'd2, ctrl);
  endtask

  task automatic wait_level(input logic lvl, output int cycles);
    cycles = 0;
    while (ser_out !== lvl && cycles < 40000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  // drive one frame onto the receive line: par 0=none 1=even 2=odd
  task automatic send(input logic [7:0] d, input int nd, input int par, input bit bad_par,
                      input bit stop_low, input int per);
    logic p;
    p = 1'b0;
    for (int i = 0; i < nd; i++) p = p ^ d[i];
    if (par == 2) p = ~p;
    if (bad_par) p = ~p;
    drv_line = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      drv_line = d[i];
      repeat (per) @(negedge clk);
    end
    if (par != 0) begin
      drv_line = p;
      repeat (per) @(negedge clk);
    end
    drv_line = !stop_low;
    repeat (per) @(negedge clk);
    drv_line = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // capture a transmitted frame and check it bit by bit, then check the looped-back character
  task automatic check_tx(input string req, input logic [7:0] d, input int nd, input int par,
                          input int nstop, input int per);
    logic [11:0] got, exp;
    int n, w;
    logic p;
    n = 1 + nd + (par != 0 ? 1 : 0) + nstop;
    exp = '1;
    exp[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < nd; i++) begin
      exp[1+i] = d[i];
      p = p ^ d[i];
    end
    if (par == 2) p = ~p;
    if (par != 0) exp[1+nd] = p;
    got = '1;
    wait_level(1'b0, w);
    repeat (per / 2) @(negedge clk);
    got[0] = ser_out;
    for (int k = 1; k < n; k++) begin
      repeat (per) @(negedge clk);
      got[k] = ser_out;
    end
    repeat (per) @(negedge clk);
    chk(req, "line frame bits", int'(got), int'(exp));
    rd_chk(req, "status after frame", 2'd2, 8'hC0);
    rd_chk(req, "received character", 2'd3, d & (8'hFF >> (8 - nd)));
  endtask

  task automatic t_reset_state;
    rd_chk("R4", "status after reset", 2'd2, 8'h40);
    chk("R4", "dtr_n after reset", dtr_n, 1);
    chk("R4", "rts_n after reset", rts_n, 1);
    chk("R4", "line idle after reset", ser_out, 1);
  endtask

  task automatic t_modem;
    loop = 1'b0;
    cts = 1'b1; dsr = 1'b0; dcd_n = 1'b1; ri = 1'b1; drv_line = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R2", "modem status A", 2'd0, 8'hB2);
    cts = 1'b0; dsr = 1'b1; dcd_n = 1'b0; ri = 1'b0; drv_line = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R2", "modem status B", 2'd0, 8'h40);
    rd_chk("R2", "offset 1 reads zero", 2'd1, 8'h00);
    drv_line = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_default_rate;
    int w, hi;
    setup(8'h55, 8'h6C, 1'b0);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h6C);
    chk("R5", "dtr_n asserted", dtr_n, 0);
    chk("R5", "rts_n asserted", rts_n, 0);
    wr(2'd3, 8'h55);
    wait_level(1'b0, w);
    wait_level(1'b1, w);
    wait_level(1'b0, hi);
    chk_near("R4", "default bit period (300 baud)", hi, bit_cycles(300.0), 1);
    wr(2'd0, 8'hA7);
    @(negedge clk);
    chk("R1", "line idle after register reset", ser_out, 1);
    chk("R1", "dtr_n released", dtr_n, 1);
    chk("R1", "rts_n released", rts_n, 1);
    rd_chk("R1", "status after register reset", 2'd2, 8'h40);
  endtask

  task automatic t_split_rates;
    int w, hi;
    setup(8'hEF, 8'h6C, 1'b0);
    wr(2'd3, 8'h55);
    wait_level(1'b0, w);
    wait_level(1'b1, w);
    wait_level(1'b0, hi);
    chk_near("R3", "transmit bit period at 9600", hi, bit_cycles(9600.0), 1);
    repeat (10 * bit_cycles(9600.0)) @(negedge clk);
    send(8'hA5, 8, 0, 1'b0, 1'b0, bit_cycles(19200.0));
    rd_chk("R3", "status after 19200 receive", 2'd2, 8'hC0);
    rd_chk("R3", "character at 19200", 2'd3, 8'hA5);
  endtask

  task automatic t_word_lengths;
    int per;
    per = bit_cycles(19200.0);
    setup(8'hFF, 8'h0C, 1'b1);
    wr(2'd3, 8'hFF);
    check_tx("R6", 8'hFF, 5, 0, 1, per);
    wr(2'd2, 8'h2C);
    wr(2'd3, 8'hAA);
    check_tx("R6", 8'hAA, 7, 0, 1, per);
    wr(2'd2, 8'h4C);
    wr(2'd3, 8'hF5);
    check_tx("R6", 8'hF5, 6, 0, 1, per);
    wr(2'd2, 8'h6C);
    wr(2'd3, 8'hC3);
    check_tx("R6", 8'hC3, 8, 0, 1, per);
    rd_chk("R10", "data read clears data-available", 2'd2, 8'h40);
  endtask

  task automatic t_parity;
    int per;
    per = bit_cycles(19200.0);
    setup(8'hFF, 8'hB4, 1'b1);
    wr(2'd3, 8'h07);
    check_tx("R7", 8'h07, 7, 1, 2, per);
    wr(2'd2, 8'h64);
    wr(2'd3, 8'h0F);
    check_tx("R7", 8'h0F, 8, 2, 1, per);
    wr(2'd2, 8'h84);
    wr(2'd3, 8'h13);
    check_tx("R7", 8'h13, 5, 1, 1, per);
  endtask

  task automatic spacing(input logic [7:0] ctrl, input int nbits);
    int per, w, t;
    per = bit_cycles(19200.0);
    setup(8'hFF, ctrl, 1'b1);
    wr(2'd3, 8'h81);
    repeat (3) @(negedge clk);
    wr(2'd3, 8'h7E);
    wait_level(1'b0, w);
    repeat (per * 19 / 2) @(negedge clk);
    wait_level(1'b0, t);
    chk_near("R8", "start-to-start spacing", t + per * 19 / 2, nbits * per, per / 16 + 2);
    repeat (12 * per) @(negedge clk);
  endtask

  task automatic t_stop_bits;
    spacing(8'h6C, 10);
    spacing(8'h7C, 11);
  endtask

  task automatic t_hold;
    int lows;
    int per;
    per = bit_cycles(19200.0);
    setup(8'hFF, 8'h68, 1'b1);
    wr(2'd3, 8'h5A);
    lows = 0;
    for (int i = 0; i < 3 * per; i++) begin
      @(negedge clk);
      if (ser_out == 1'b0) lows++;
    end
    chk("R12", "line low cycles while disabled", lows, 0);
    rd_chk("R12", "status while held", 2'd2, 8'h00);
    wr(2'd2, 8'h6C);
    check_tx("R12", 8'h5A, 8, 0, 1, per);
  endtask

  task automatic t_overrun;
    int per;
    per = bit_cycles(19200.0);
    setup(8'hFF, 8'h6C, 1'b1);
    wr(2'd3, 8'h11);
    repeat (11 * per) @(negedge clk);
    wr(2'd3, 8'h22);
    repeat (11 * per) @(negedge clk);
    rd_chk("R10", "status with overrun", 2'd2, 8'hE0);
    rd_chk("R10", "newest character kept", 2'd3, 8'h22);
    rd_chk("R10", "flags cleared by data read", 2'd2, 8'h40);
  endtask

  task automatic t_errors;
    int per;
    per = bit_cycles(19200.0);
    setup(8'hFF, 8'h6C, 1'b0);
    send(8'h3C, 8, 0, 1'b0, 1'b1, per);
    rd_chk("R11", "framing error status", 2'd2, 8'hD0);
    rd_chk("R11", "character with bad stop", 2'd3, 8'h3C);
    wr(2'd2, 8'hE4);
    send(8'h01, 8, 1, 1'b1, 1'b0, per);
    rd_chk("R11", "parity error status", 2'd2, 8'hC8);
    rd_chk("R11", "character with bad parity", 2'd3, 8'h01);
    send(8'h02, 8, 1, 1'b0, 1'b0, per);
    rd_chk("R11", "errors follow last character", 2'd2, 8'hC0);
    rd_chk("R11", "good parity character", 2'd3, 8'h02);
  endtask

  task automatic t_glitch;
    int per;
    per = bit_cycles(19200.0);
    setup(8'hFF, 8'h6C, 1'b0);
    drv_line = 1'b0;
    repeat (per * 3 / 8) @(negedge clk);
    drv_line = 1'b1;
    repeat (2 * per) @(negedge clk);
    rd_chk("R13", "short low pulse ignored", 2'd2, 8'h40);
    send(8'h96, 8, 0, 1'b0, 1'b0, per);
    rd_chk("R13", "status after real frame", 2'd2, 8'hC0);
    rd_chk("R13", "real frame received", 2'd3, 8'h96);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_modem();
    t_default_rate();
    t_split_rates();
    t_word_lengths();
    t_parity();
    t_stop_bits();
    t_hold();
    t_overrun();
    t_errors();
    t_glitch();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule